// File: doc/BRIEF.md
# Charge Pump Gain Mode Controller

This block chooses the voltage gain of a charge pump that feeds a bank of LED current sinks. It can pass the input through (1x) or boost it by 1.5x or 2x. Every input is an already-digitised comparator result or event strobe. Those inputs are per-sink low-headroom flags, output-below-input, dropout, output short and over-temperature. A channel-disable strobe comes from the dimming logic, and a shutdown level comes from the system. All dwell and retry timing is counted on a tick-enable input, so the time base is set outside the block.

The gain only rises one step at a time. It always passes through 1.5x and waits a dwell there before 2x is allowed. While boosted, the controller drops back one step at a fixed retry interval to test whether a lower gain is now enough, and it climbs again only if the flags still call for it. Fault inputs override the normal selection and release it once they clear.

Top module: `cp_gain_ctrl`

## Requirements
- R1: While `shutdown` is high, the next clock edge sets 1x (`gain_sel` = 3'b001) with `pump_en` low and clears both timers. After shutdown is released, selection resumes from 1x. An active-low reset gives the same state.
- R2: In 1x, the gain moves to 1.5x on the next edge if any sink has both its `ch_active` bit and its `headroom_low` bit set. Headroom flags from sinks whose `ch_active` bit is 0 have no effect, and the gain stays at 1x.
- R3: In 1.5x with `dropout` high, the move to 2x happens only after the dwell timer has counted DWELL_TICKS ticks since 1.5x was entered. 1x never goes straight to 2x.
- R4: In 1.5x, the retry timer counts ticks only while `out_below_in` is high and is cleared while it is low. On the edge after it reaches RETRY_TICKS, the gain returns to 1x.
- R5: In 2x, the retry timer counts ticks without any qualifier. On the edge after it reaches RETRY_TICKS, the gain returns to 1.5x.
- R6: In 2x, a `ch_disable_evt` strobe moves the gain to 1.5x on the next edge.
- R7: While `out_short` is high (and neither shutdown nor over-temperature is active), the block holds 1x with `pump_en` high. Normal selection resumes when the flag clears.
- R8: While `over_temp` is high (and shutdown is low), `pump_en` is low and the gain is 1x. Operation restarts from 1x when the flag clears.
- R9: `gain_sel` is always one-hot. Bit 0 means 1x, bit 1 means 1.5x and bit 2 means 2x.
- R10: In 1.5x, if the dwell is complete with `dropout` high in the same cycle that the retry timer is expired, escalation to 2x takes priority over the drop to 1x.
- R11: Both timers restart from zero on every gain change. After a retry drop from 2x, 2x is therefore re-entered only after a full new dwell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | Global shutdown level |
| tick | input | 1 | Time-base enable for the dwell and retry timers |
| ch_active | input | NUM_CH | Per-sink enable mask for headroom flags |
| headroom_low | input | NUM_CH | Per-sink headroom-below-threshold flag |
| out_below_in | input | 1 | Pump output is below its input |
| dropout | input | 1 | Dropout detected at the current gain |
| out_short | input | 1 | Output pulled below the short threshold |
| over_temp | input | 1 | Die over-temperature flag |
| ch_disable_evt | input | 1 | One-cycle strobe: a channel group was disabled |
| gain_sel | output | 3 | One-hot gain: bit0 1x, bit1 1.5x, bit2 2x |
| pump_en | output | 1 | Charge pump enable |

## Verification
In 1.5x, completing the dwell with dropout present and expiring the retry timer can fall on the same clock edge. The first pushes the gain up and the second pulls it down. The bench sets up this coincidence directly. It enters 1.5x with `out_below_in` held and `dropout` low, lets exactly RETRY_TICKS ticks pass so that both timers are complete, and then raises `dropout` with the tick gated off. It then expects 2x on the following edge. Random stimulus reaches the same coincidence along with the fault overrides, and a cycle-level model in the bench judges each of those cases.

// File: rtl/cp_gain_pkg.sv
package cp_gain_pkg;

    typedef enum logic [1:0] {
        GAIN_1X  = 2'd0,
        GAIN_15X = 2'd1,
        GAIN_2X  = 2'd2
    } gain_e;

    typedef struct packed {
        gain_e gain;
        logic  pump_en;
    } ctrl_s;

endpackage

// File: rtl/cp_headroom_mask.sv
module cp_headroom_mask #(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0] ch_active,
    input  logic [NUM_CH-1:0] headroom_low,
    output logic              any_low
);

    logic [NUM_CH-1:0] qualified;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign qualified[ch] = ch_active[ch] & headroom_low[ch];
    end

    assign any_low = |qualified;

endmodule

// File: rtl/cp_tick_timer.sv
module cp_tick_timer #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);

    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    assign done = (cnt_q == LIM);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && !done) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R11: a clear request restarts the count
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R11: the count saturates at its limit
    p_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cnt_q == LIM) || (cnt_q == '0));

endmodule

// File: rtl/cp_gain_ctrl.sv
module cp_gain_ctrl
    import cp_gain_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int DWELL_TICKS = 10,
    parameter int RETRY_TICKS = 130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shutdown,
    input  logic              tick,
    input  logic [NUM_CH-1:0] ch_active,
    input  logic [NUM_CH-1:0] headroom_low,
    input  logic              out_below_in,
    input  logic              dropout,
    input  logic              out_short,
    input  logic              over_temp,
    input  logic              ch_disable_evt,
    output logic [2:0]        gain_sel,
    output logic              pump_en
);

    ctrl_s st_d, st_q;
    logic  any_low;
    logic  normal;
    logic  gain_change;
    logic  dwell_clr, dwell_done;
    logic  retry_clr, retry_done;

    cp_headroom_mask #(.NUM_CH(NUM_CH)) u_mask (
        .ch_active    (ch_active),
        .headroom_low (headroom_low),
        .any_low      (any_low)
    );

    cp_tick_timer #(.LIMIT(DWELL_TICKS)) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dwell_clr),
        .tick  (tick),
        .done  (dwell_done)
    );

    cp_tick_timer #(.LIMIT(RETRY_TICKS)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (retry_clr),
        .tick  (tick),
        .done  (retry_done)
    );

    assign normal = !shutdown && !over_temp && !out_short;

    always_comb begin
        st_d = st_q;
        if (shutdown || over_temp) begin
            st_d.gain    = GAIN_1X;
            st_d.pump_en = 1'b0;
        end else if (out_short) begin
            st_d.gain    = GAIN_1X;
            st_d.pump_en = 1'b1;
        end else begin
            st_d.pump_en = 1'b1;
            unique case (st_q.gain)
                GAIN_1X: begin
                    if (any_low) st_d.gain = GAIN_15X;
                end
                GAIN_15X: begin
                    if (dropout && dwell_done)  st_d.gain = GAIN_2X;
                    else if (retry_done)        st_d.gain = GAIN_1X;
                end
                GAIN_2X: begin
                    if (ch_disable_evt || retry_done) st_d.gain = GAIN_15X;
                end
                default: st_d.gain = GAIN_1X;
            endcase
        end
    end

    assign gain_change = (st_d.gain != st_q.gain);
    assign dwell_clr   = gain_change || !normal || (st_q.gain != GAIN_15X);
    assign retry_clr   = gain_change || !normal || (st_q.gain == GAIN_1X)
                       || ((st_q.gain == GAIN_15X) && !out_below_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{gain: GAIN_1X, pump_en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gain_sel = 3'b001 << st_q.gain;
    assign pump_en  = st_q.pump_en;

    // R9: exactly one gain selected
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gain_sel) == 1);

    // R1: shutdown forces 1x with the pump off
    p_shutdown_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (gain_sel == 3'b001) && !pump_en);

    // R8: over-temperature turns the pump off
    p_overtemp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |=> !pump_en && (gain_sel == 3'b001));

    // R7: short holds 1x with the pump on
    p_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_short && !shutdown && !over_temp) |=> (gain_sel == 3'b001) && pump_en);

    // R3: 1x never jumps straight to 2x
    p_no_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_sel == 3'b001) |=> (gain_sel != 3'b100));

    // R6: disable event in 2x returns to 1.5x
    p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (normal && gain_sel == 3'b100 && ch_disable_evt) |=> (gain_sel == 3'b010));

    // R2: masked or clear headroom keeps 1x
    p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (normal && gain_sel == 3'b001 && ((ch_active & headroom_low) == '0))
        |=> (gain_sel == 3'b001));

endmodule

// File: tb/cp_gain_ctrl_bench.sv
module cp_gain_ctrl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCH = 6;
    localparam int DW  = 10;
    localparam int RT  = 130;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           shutdown = 1'b0, tick = 1'b0;
    logic [NCH-1:0] ch_active = '1, headroom_low = '0;
    logic           out_below_in = 1'b0, dropout = 1'b0, out_short = 1'b0;
    logic           over_temp = 1'b0, ch_disable_evt = 1'b0;
    logic [2:0]     gain_sel;
    logic           pump_en;

    always #4 clk = ~clk;

    cp_gain_ctrl #(.NUM_CH(NCH), .DWELL_TICKS(DW), .RETRY_TICKS(RT)) u_cp_gain_ctrl (
        .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .tick(tick),
        .ch_active(ch_active), .headroom_low(headroom_low),
        .out_below_in(out_below_in), .dropout(dropout), .out_short(out_short),
        .over_temp(over_temp), .ch_disable_evt(ch_disable_evt),
        .gain_sel(gain_sel), .pump_en(pump_en)
    );

    // stimulus for the next edge
    logic           s_rst = 1'b0, s_sd = 1'b0, s_tk = 1'b0, s_obi = 1'b0;
    logic           s_dr = 1'b0, s_sh = 1'b0, s_ot = 1'b0, s_dev = 1'b0;
    logic [NCH-1:0] s_act = '1, s_hl = '0;

    // reference model state
    int    m_gain = 0, m_dwell = 0, m_retry = 0;
    bit    m_pump = 1'b0;
    string m_tag = "R1";
    int    n_gain = 0, n_dwell = 0, n_retry = 0;
    bit    n_pump = 1'b0;
    string n_tag = "R1";

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    task automatic model_next();
        bit normal, dd, rd, chg, dclr, rclr;
        normal = !s_sd && !s_ot && !s_sh;
        dd = (m_dwell == DW);
        rd = (m_retry == RT);
        if (!s_rst) begin
            n_gain = 0; n_pump = 0; n_dwell = 0; n_retry = 0; n_tag = "R1";
            return;
        end
        n_gain = m_gain;
        if (s_sd) begin
            n_gain = 0; n_pump = 0; n_tag = "R1";
        end else if (s_ot) begin
            n_gain = 0; n_pump = 0; n_tag = "R8";
        end else if (s_sh) begin
            n_gain = 0; n_pump = 1; n_tag = "R7";
        end else begin
            n_pump = 1;
            if (m_gain == 0) begin
                n_tag = "R2";
                if ((s_act & s_hl) != '0) n_gain = 1;
            end else if (m_gain == 1) begin
                n_tag = (s_dr && !dd) ? "R11" : "R4";
                if (s_dr && dd) begin
                    n_gain = 2; n_tag = rd ? "R10" : "R3";
                end else if (rd) begin
                    n_gain = 0;
                end
            end else begin
                n_tag = "R5";
                if (s_dev) begin
                    n_gain = 1; n_tag = "R6";
                end else if (rd) begin
                    n_gain = 1;
                end
            end
        end
        chg  = (n_gain != m_gain);
        dclr = chg || !normal || (m_gain != 1);
        rclr = chg || !normal || (m_gain == 0) || ((m_gain == 1) && !s_obi);
        n_dwell = dclr ? 0 : ((s_tk && !dd) ? m_dwell + 1 : m_dwell);
        n_retry = rclr ? 0 : ((s_tk && !rd) ? m_retry + 1 : m_retry);
    endtask

    task automatic step();
        logic [2:0] exp_sel;
        @(negedge clk);
        if (finished) return;
        m_gain = n_gain; m_pump = n_pump; m_dwell = n_dwell; m_retry = n_retry; m_tag = n_tag;
        exp_sel = 3'b001 << m_gain;
        checks++;
        if (gain_sel !== exp_sel) begin
            failures++;
            $display("FAIL %s gain_sel actual=%b expected=%b at %0t", m_tag, gain_sel, exp_sel, $time);
        end
        checks++;
        if (pump_en !== m_pump) begin
            failures++;
            $display("FAIL %s pump_en actual=%b expected=%b at %0t", m_tag, pump_en, m_pump, $time);
        end
        checks++;
        if ($countones(gain_sel) != 1) begin
            failures++;
            $display("FAIL R9 one-hot actual=%b expected=one bit set", gain_sel);
        end
        rst_n = s_rst; shutdown = s_sd; tick = s_tk; ch_active = s_act;
        headroom_low = s_hl; out_below_in = s_obi; dropout = s_dr;
        out_short = s_sh; over_temp = s_ot; ch_disable_evt = s_dev;
        model_next();
    endtask

    task automatic quiet();
        s_sd = 0; s_ot = 0; s_sh = 0; s_dev = 0; s_dr = 0; s_obi = 0;
        s_hl = '0; s_act = '1; s_tk = 1;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_gain(logic [2:0] want, string tag);
        int guard = 0;
        while (gain_sel !== want && guard < 2000) begin
            step();
            guard++;
        end
        checks++;
        if (gain_sel !== want) begin
            failures++;
            $display("FAIL %s waiting gain actual=%b expected=%b", tag, gain_sel, want);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        s_rst = 0;
        run(3);
        s_rst = 1;
        quiet();
        s_sd = 1;
        run(4);                       // R1 shutdown holds 1x, pump off

        // random phase
        for (int c = 0; c < 40000; c++) begin
            if (!s_sd) s_sd = ($urandom % 3000) == 0; else s_sd = ($urandom % 5) != 0;
            if (!s_ot) s_ot = ($urandom % 3000) == 0; else s_ot = ($urandom % 5) != 0;
            if (!s_sh) s_sh = ($urandom % 2500) == 0; else s_sh = ($urandom % 5) != 0;
            s_dev = ($urandom % 400) == 0;
            if (($urandom % 50) == 0) s_dr = !s_dr;
            if (($urandom % 300) == 0) s_obi = !s_obi;
            if (($urandom % 500) == 0) s_act = NCH'($urandom);
            s_hl = (($urandom % 6) == 0) ? NCH'($urandom) : '0;
            s_tk = $urandom % 2;
            step();
        end

        // R1: shutdown from any state
        quiet(); s_sd = 1; run(5);
        // R2: headroom on masked sinks only
        quiet(); s_act = 6'b000111; s_hl = 6'b111000; run(20);
        // R2/R3/R11: escalate, dwell, 2x retry, re-dwell
        s_hl = 6'b000001; s_dr = 1; s_obi = 1;
        wait_gain(3'b010, "R2");
        wait_gain(3'b100, "R3");
        wait_gain(3'b010, "R5");
        wait_gain(3'b100, "R11");
        // R6: disable event in 2x
        s_dev = 1; step(); s_dev = 0; step();
        // R4: 1.5x retry back to 1x with no dropout
        s_dr = 0; s_hl = '0;
        wait_gain(3'b001, "R4");
        // R10: dwell+dropout coincides with retry expiry
        s_hl = 6'b000010; s_dr = 0; s_obi = 1; s_tk = 1;
        wait_gain(3'b010, "R10");
        s_hl = '0;
        run(RT - 1);
        s_tk = 0; s_dr = 1;
        step(); step();
        checks++;
        if (gain_sel !== 3'b100) begin
            failures++;
            $display("FAIL R10 coincident gain actual=%b expected=100", gain_sel);
        end
        // R7: short
        s_sh = 1; run(4); s_sh = 0; s_dr = 0; run(3);
        // R8: over-temperature
        s_ot = 1; run(4); s_ot = 0; run(3);
        run(2);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule